// File: doc/BRIEF.md
# Flash Program/Erase Status Byte Generator

This block sits on the read path of a flash device and decides, on every read, whether the bus carries array data or a status byte. It does not run program or erase itself. An external engine reports what it is doing through a set of flags:

- whether it is busy or suspended,
- whether the current operation is a program or an erase,
- whether erasing has actually begun,
- a pulse when an operation fails.

The block also receives the block index of each read, the set of blocks picked for erase, the protected set, and the per-block erase-failure set.

The status byte carries five reporting bits:

- Bit 7 is a polling bit that reports the complement of the value being written.
- Bit 6 is a general toggle bit that inverts on each read while the engine works.
- Bit 5 is a sticky error bit.
- Bit 3 is an erase-timer bit.
- Bit 2 is an address-qualified toggle bit that inverts only for reads that land in blocks really being erased.

Both toggle bits advance on the rising edge of the read strobe. Host software polls these bits to find out when an operation has ended and whether it failed.

Top module: `fsr_top`

## Requirements
- R1: While the engine is busy, or the error bit is set, `dataOut` carries the status byte. When idle and not suspended with no error, `dataOut` equals `arrayData`.
- R2: Bit 7 of the status byte equals the inverse of `progBit7` during a program operation (`opErase`=0) and reads 0 during an erase (`opErase`=1).
- R3: While `suspended` is high, a read whose block is selected for erase and not protected returns the status byte with bit 7 at 1. A read of any other block returns `arrayData`.
- R4: While `busy` is high and `suspended` is low, bit 6 inverts once for each rising edge of `rdStrobe`, whatever the block address.
- R5: Bit 6 keeps its value on reads while `suspended` is high or `busy` is low.
- R6: An `errSet` pulse sets bit 5, which then stays set until a `rstCmd` pulse clears it. When both pulses arrive in the same cycle, the bit ends up set.
- R7: Bit 3 reads 1 when an erase is in progress and `eraseStarted` is high. It reads 0 while blocks may still be added (`eraseStarted`=0) and during programs.
- R8: During an erase, or an erase suspend, bit 2 inverts on a read rising edge only when the read block is selected in `eraseSel` and clear in `protMask`. Reads of other blocks leave it unchanged, and bit 2 never moves during a program.
- R9: Once the error bit is set after an erase, bit 2 inverts only on reads of blocks flagged in `failMask` and holds for reads of blocks that erased correctly.
- R10: Status bits 4, 1 and 0, and any bits above bit 7, read 0.
- R11: After reset both toggle bits are 0 and the error bit is clear, so an idle read returns `arrayData`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busy | input | 1 | Engine is running a program or erase |
| suspended | input | 1 | Erase is suspended |
| opErase | input | 1 | Current operation is an erase (0 = program) |
| eraseStarted | input | 1 | Erase has begun; no more blocks can be added |
| errSet | input | 1 | One-cycle pulse: the operation failed |
| rstCmd | input | 1 | One-cycle pulse: a reset command was decoded |
| progBit7 | input | 1 | Bit 7 of the value being programmed |
| rdStrobe | input | 1 | Read strobe; toggles advance on its rising edge |
| rdBlock | input | BLK_W | Block index of the current read |
| eraseSel | input | NUM_BLOCKS | Blocks selected for erase |
| protMask | input | NUM_BLOCKS | Protected blocks |
| failMask | input | NUM_BLOCKS | Blocks whose erase failed |
| arrayData | input | DATA_W | Data read from the array |
| dataOut | output | DATA_W | Read data or status byte |
| statusOut | output | 1 | High when `dataOut` carries the status byte |

## Verification
The bench builds the block with eight blocks and an eight-bit data path. This is enough to hold, at the same time:

- a block that is selected and unprotected,
- a block that is selected but protected,
- unselected blocks,
- a failed block beside a block that erased correctly.

With all of these present, the address rules of bit 2 are checked against each other within one run. The eight-bit width puts every status bit position on a real pin, so the zero bits and the inverted polling bit are observed directly.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
  // Bit positions inside the status byte (host software decodes these)
  localparam int POLL_POS  = 7;
  localparam int TOG_POS   = 6;
  localparam int ERR_POS   = 5;
  localparam int TIMER_POS = 3;
  localparam int ALT_POS   = 2;

  // Strobes and static bits from control to datapath
  typedef struct packed {
    logic statusActive;
    logic flipTog;
    logic flipAlt;
    logic pollBit;
    logic errBit;
    logic timerBit;
  } statStrb_t;
endpackage

// File: rtl/fsr_ctrl.sv
`timescale 1ns/1ps
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busy,
  input  logic                  suspended,
  input  logic                  opErase,
  input  logic                  eraseStarted,
  input  logic                  errSet,
  input  logic                  rstCmd,
  input  logic                  progBit7,
  input  logic                  rdStrobe,
  input  logic [BLK_W-1:0]      rdBlock,
  input  logic [NUM_BLOCKS-1:0] eraseSel,
  input  logic [NUM_BLOCKS-1:0] protMask,
  input  logic [NUM_BLOCKS-1:0] failMask,
  output statStrb_t             strb
);

  logic rdPrev;
  logic errLatch;
  logic rdRise;
  logic [NUM_BLOCKS-1:0] blkHit;
  logic [NUM_BLOCKS-1:0] effSel;
  logic inErase;
  logic failHit;
  logic altWindow;
  logic altOk;

  // One-hot decode of the read block index
  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_dec
    assign blkHit[g] = (rdBlock == BLK_W'(g));
  end

  // A protected block counts as not selected
  assign effSel  = eraseSel & ~protMask;
  assign inErase = |(blkHit & effSel);
  assign failHit = |(blkHit & failMask);
  assign rdRise  = rdStrobe & ~rdPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev   <= 1'b0;
      errLatch <= 1'b0;
    end else begin
      rdPrev <= rdStrobe;
      if (errSet)      errLatch <= 1'b1;
      else if (rstCmd) errLatch <= 1'b0;
    end
  end

  always_comb begin
    altWindow = opErase && (busy || suspended || errLatch);
    altOk     = inErase && (!errLatch || failHit);
    strb.statusActive = errLatch || (suspended ? inErase : busy);
    strb.flipTog  = rdRise && busy && !suspended;
    strb.flipAlt  = rdRise && altWindow && altOk;
    strb.pollBit  = suspended ? 1'b1 : (opErase ? 1'b0 : ~progBit7);
    strb.errBit   = errLatch;
    strb.timerBit = opErase && eraseStarted;
  end

  // R6: error stays set until a reset command
  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.errBit && !rstCmd) |=> strb.errBit);
  // R6: reset command clears the error when no new failure arrives
  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rstCmd && !errSet) |=> !strb.errBit);
  // R5: general toggle never advances during suspend
  p_no_tog_suspend_r5: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> !strb.flipTog);
  // R8: reads of protected blocks never advance the address toggle
  p_prot_alt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|(blkHit & protMask)) |-> !strb.flipAlt);

endmodule

// File: rtl/fsr_dpath.sv
`timescale 1ns/1ps
module fsr_dpath
  import fsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStrb_t         strb,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              statusOut
);

  logic togQ;
  logic altQ;
  logic [DATA_W-1:0] statByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      togQ <= 1'b0;
      altQ <= 1'b0;
    end else begin
      if (strb.flipTog) togQ <= ~togQ;
      if (strb.flipAlt) altQ <= ~altQ;
    end
  end

  always_comb begin
    statByte            = '0;
    statByte[POLL_POS]  = strb.pollBit;
    statByte[TOG_POS]   = togQ;
    statByte[ERR_POS]   = strb.errBit;
    statByte[TIMER_POS] = strb.timerBit;
    statByte[ALT_POS]   = altQ;
  end

  assign statusOut = strb.statusActive;
  assign dataOut   = strb.statusActive ? statByte : arrayData;

  // R4: a flip strobe inverts the general toggle at the next edge
  p_tog_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.flipTog |=> (togQ != $past(togQ)));
  // R5: without a flip strobe the general toggle holds
  p_tog_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.flipTog |=> $stable(togQ));
  // R8: without an address flip strobe the address toggle holds
  p_alt_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.flipAlt |=> $stable(altQ));

endmodule

// File: rtl/fsr_top.sv
`timescale 1ns/1ps
module fsr_top
  import fsr_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 8,
  localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busy,
  input  logic                  suspended,
  input  logic                  opErase,
  input  logic                  eraseStarted,
  input  logic                  errSet,
  input  logic                  rstCmd,
  input  logic                  progBit7,
  input  logic                  rdStrobe,
  input  logic [BLK_W-1:0]      rdBlock,
  input  logic [NUM_BLOCKS-1:0] eraseSel,
  input  logic [NUM_BLOCKS-1:0] protMask,
  input  logic [NUM_BLOCKS-1:0] failMask,
  input  logic [DATA_W-1:0]     arrayData,
  output logic [DATA_W-1:0]     dataOut,
  output logic                  statusOut
);

  statStrb_t strb;

  fsr_ctrl #(.NUM_BLOCKS(NUM_BLOCKS)) i_ctrl (
    .clk(clk), .rstN(rstN), .busy(busy), .suspended(suspended),
    .opErase(opErase), .eraseStarted(eraseStarted), .errSet(errSet),
    .rstCmd(rstCmd), .progBit7(progBit7), .rdStrobe(rdStrobe),
    .rdBlock(rdBlock), .eraseSel(eraseSel), .protMask(protMask),
    .failMask(failMask), .strb(strb)
  );

  fsr_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .arrayData(arrayData),
    .dataOut(dataOut), .statusOut(statusOut)
  );

endmodule

// File: tb/test_fsr_top.sv
`timescale 1ns/1ps
module test_fsr_top;
  logic clk = 1'b0;
  logic rstN, busy, susp, opE, started, errSet, rstCmd, pb7, rdS;
  logic [2:0] rdBlk;
  logic [7:0] eSel, prot, fail, arr, dataOut;
  logic statusOut;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  logic t6 = 1'b0;
  logic t2 = 1'b0;
  logic errExp = 1'b0;

  always #2.5 clk = ~clk;

  fsr_top i_fsr_top (
    .clk(clk), .rstN(rstN), .busy(busy), .suspended(susp), .opErase(opE),
    .eraseStarted(started), .errSet(errSet), .rstCmd(rstCmd), .progBit7(pb7),
    .rdStrobe(rdS), .rdBlock(rdBlk), .eraseSel(eSel), .protMask(prot),
    .failMask(fail), .arrayData(arr), .dataOut(dataOut), .statusOut(statusOut)
  );

  // {busy,susp,opE,started,pb7,blk[2:0],arr[7:0],exp[7:0]}
  localparam logic [23:0] VEC [9] = '{
    {5'b00000, 3'd5, 8'hA5, 8'hA5},  // R1 idle -> array
    {5'b10001, 3'd0, 8'h3C, 8'h00},  // R2 program, bit7 of target 1
    {5'b10000, 3'd0, 8'h3C, 8'h80},  // R2 program, bit7 of target 0
    {5'b10100, 3'd2, 8'h3C, 8'h00},  // R7 erase, not yet started
    {5'b10110, 3'd2, 8'h3C, 8'h08},  // R7 erase started
    {5'b01110, 3'd2, 8'h3C, 8'h88},  // R3 suspend, erasing block
    {5'b01110, 3'd5, 8'h3C, 8'h3C},  // R3 suspend, other block
    {5'b01110, 3'd3, 8'h5A, 8'h5A},  // R3 suspend, protected block
    {5'b10000, 3'd1, 8'hFF, 8'h80}   // R10 zero bits with all-ones array
  };

  function automatic logic [7:0] sb(logic b7, logic b6, logic b5, logic b3, logic b2);
    return {b7, b6, b5, 1'b0, b3, b2, 2'b00};
  endfunction

  task automatic check(logic [7:0] exp, string tag);
    nChecks++;
    if (dataOut !== exp) begin
      nFails++;
      $display("FAIL %s: dataOut=%h expected=%h", tag, dataOut, exp);
    end
  endtask

  // One read pulse; expected toggle bits follow the requirement rules
  task automatic doRead();
    logic selOk;
    selOk = eSel[rdBlk] && !prot[rdBlk];
    if (busy && !susp) t6 = ~t6;
    if (opE && (busy || susp || errExp) && selOk && (!errExp || fail[rdBlk])) t2 = ~t2;
    @(negedge clk) rdS = 1'b1;
    @(negedge clk) rdS = 1'b0;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not end");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 0; busy = 0; susp = 0; opE = 0; started = 0; errSet = 0; rstCmd = 0;
    pb7 = 0; rdS = 0; rdBlk = 0; eSel = 8'h0C; prot = 8'h08; fail = 8'h00; arr = 8'h5A;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check(8'h5A, "R11 idle after reset");
    nChecks++;
    if (statusOut !== 1'b0) begin
      nFails++;
      $display("FAIL R11: statusOut=%b expected=0", statusOut);
    end

    // Vector table (no reads yet, toggles still 0)
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      {busy, susp, opE, started, pb7, rdBlk, arr} = VEC[i][23:8];
      #1;
      check(VEC[i][7:0], $sformatf("R1/R2/R3/R7/R10 vector %0d", i));
    end

    // R4: program, bit6 toggles at any address; bit2 stays put
    @(negedge clk);
    busy = 1; susp = 0; opE = 0; started = 0; pb7 = 1; arr = 8'h00;
    foreach (VEC[k]) if (k < 3) begin
      rdBlk = 3'(k * 3);
      doRead();
      check(sb(1'b0, t6, 1'b0, 1'b0, t2), "R4 program toggle");
    end

    // R8: erase, address-qualified toggle
    opE = 1; started = 1;
    rdBlk = 3; doRead(); check(sb(1'b0, t6, 1'b0, 1'b1, t2), "R8 protected block holds bit2");
    rdBlk = 2; doRead(); check(sb(1'b0, t6, 1'b0, 1'b1, t2), "R8 selected block flips bit2");
    rdBlk = 0; doRead(); check(sb(1'b0, t6, 1'b0, 1'b1, t2), "R8 unselected block holds bit2");

    // R5: suspend freezes bit6, bit2 still advances in erasing block
    busy = 0; susp = 1; rdBlk = 2;
    doRead(); check(sb(1'b1, t6, 1'b0, 1'b1, t2), "R5 suspend read 1");
    doRead(); check(sb(1'b1, t6, 1'b0, 1'b1, t2), "R5 suspend read 2");
    arr = 8'h77; rdBlk = 5;
    doRead(); check(8'h77, "R3 suspend non-erasing block array");
    rdBlk = 2; #1;
    check(sb(1'b1, t6, 1'b0, 1'b1, t2), "R8 bit2 unchanged by other-block read");

    // R6: error latch
    susp = 0; busy = 1;
    @(negedge clk) errSet = 1;
    @(negedge clk) errSet = 0; busy = 0; errExp = 1;
    #1;
    check(sb(1'b0, t6, 1'b1, 1'b1, t2), "R6 error set");
    repeat (3) @(negedge clk);
    #1;
    check(sb(1'b0, t6, 1'b1, 1'b1, t2), "R6 error held");

    // R9: after error, bit2 only for failed blocks
    eSel = 8'h06; prot = 8'h00; fail = 8'h04;
    rdBlk = 1; doRead(); check(sb(1'b0, t6, 1'b1, 1'b1, t2), "R9 good block holds bit2");
    rdBlk = 2; doRead(); check(sb(1'b0, t6, 1'b1, 1'b1, t2), "R9 failed block flips bit2");

    // R6: simultaneous set and clear keeps the error
    @(negedge clk) begin errSet = 1; rstCmd = 1; end
    @(negedge clk) begin errSet = 0; rstCmd = 0; end
    #1;
    check(sb(1'b0, t6, 1'b1, 1'b1, t2), "R6 set wins over clear");
    @(negedge clk) rstCmd = 1;
    @(negedge clk) rstCmd = 0; errExp = 0;
    arr = 8'hC3; #1;
    check(8'hC3, "R6/R1 reset command clears error");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule